// File: doc/BRIEF.md
# Accumulator Immediate-Instruction Executor

This block is a tiny sequenced datapath. A program counter walks an internal read-only program whose contents come from a parameter array. Each 16-bit word carries an operation code and an 8-bit operand. On every clock edge, one word is applied to a single 16-bit accumulator.

The supported operations are add, subtract, load, AND and OR, all with an immediate operand. Add and subtract treat the operand as a signed byte. Load, AND and OR treat it as an unsigned byte.

An all-zero word ends the program. It freezes the counter and the accumulator, and it raises a halted flag that stays up until reset. The accumulator, the counter and the flag are the only outputs. A host reads them to learn the result of the built-in program.

Top module: `acc_exec`

## Requirements
- R1: Each word is 16 bits wide, with the operation code in bits 15:8 and the immediate in bits 7:0. While the block is not halted, each rising edge executes the word addressed by the counter and increments the counter by one. The accumulator shows the result right after that edge.
- R2: Code 0x09 adds the sign-extended immediate to the accumulator, modulo 2^16. An immediate of 0xff therefore decrements the accumulator.
- R3: Code 0x0d subtracts the sign-extended immediate from the accumulator, modulo 2^16. An immediate of 0x80 therefore adds 128.
- R4: Code 0x21 replaces the accumulator with the zero-extended immediate.
- R5: Code 0x23 sets the accumulator to its bitwise AND with the zero-extended immediate.
- R6: Code 0x25 sets the accumulator to its bitwise OR with the zero-extended immediate.
- R7: Fetching the word 0x0000 sets the halted flag on the next edge and leaves the counter on that word's address. Once halted, the counter, the accumulator and the flag hold until reset.
- R8: Any other operation code, including 0x00 with a nonzero immediate, leaves the accumulator unchanged and still advances the counter.
- R9: The active-low asynchronous reset clears the accumulator and the counter to zero and clears the halted flag.
- R10: An address at or beyond the program depth reads as 0x0000. A program with no end word therefore halts with the counter equal to the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_o | output | 16 | Current accumulator value |
| pc_o | output | $clog2(PROG_DEPTH+1) | Address of the word fetched next |
| halted_o | output | 1 | High once the end word has been fetched |

## Verification
The block has no data inputs, so the only assumption the properties make is that reset is released cleanly and then stays high. Each property is disabled while reset is low. Stimulus is therefore the choice of program. One program covers every operation code, both signs of arithmetic operand, wrap in both directions, unknown codes with a zero and a nonzero high byte, and an end word followed by dead entries. A second instance runs a short program with no end word to reach the depth limit.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned OPC_W   = 8;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned ACC_W   = 16;

  localparam logic [OPC_W-1:0] OPC_ADD = 8'h09;
  localparam logic [OPC_W-1:0] OPC_SUB = 8'h0d;
  localparam logic [OPC_W-1:0] OPC_LD  = 8'h21;
  localparam logic [OPC_W-1:0] OPC_AND = 8'h23;
  localparam logic [OPC_W-1:0] OPC_OR  = 8'h25;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_ADD,
    OP_SUB,
    OP_LOAD,
    OP_AND,
    OP_OR
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [ACC_W-1:0] operand;
    logic             is_end;
  } dec_t;

  localparam int unsigned DEFAULT_DEPTH = 8;
  localparam logic [INSTR_W-1:0] DEFAULT_PROG [DEFAULT_DEPTH] = '{
    16'h2110, 16'h0905, 16'h09ff, 16'h0d01,
    16'h23f3, 16'h2508, 16'h0000, 16'h0000
  };

endpackage

// File: rtl/acc_exec_rom.sv
module acc_exec_rom
  import acc_exec_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = $clog2(DEPTH + 1),
  parameter logic [INSTR_W-1:0] PROG [DEPTH] = '{default: '0}
) (
  input  logic [PC_W-1:0]    addr_i,
  output logic [INSTR_W-1:0] word_o
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [INSTR_W-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign entry[g] = PROG[g];
  end

  logic in_range;
  assign in_range = addr_i < PC_W'(DEPTH);

  // out-of-range reads return the end word
  always_comb begin
    word_o = '0;
    if (in_range) word_o = entry[addr_i[IDX_W-1:0]];
  end

endmodule

// File: rtl/acc_exec_decode.sv
module acc_exec_decode
  import acc_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output dec_t               dec_o
);

  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;
  logic [ACC_W-1:0] imm_sx;
  logic [ACC_W-1:0] imm_zx;

  assign opc    = word_i[INSTR_W-1 -: OPC_W];
  assign imm    = word_i[IMM_W-1:0];
  assign imm_sx = {{(ACC_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_zx = {{(ACC_W-IMM_W){1'b0}}, imm};

  always_comb begin
    dec_o.is_end  = (word_i == '0);
    dec_o.op      = OP_NOP;
    dec_o.operand = imm_zx;
    unique case (opc)
      OPC_ADD: begin dec_o.op = OP_ADD;  dec_o.operand = imm_sx; end
      OPC_SUB: begin dec_o.op = OP_SUB;  dec_o.operand = imm_sx; end
      OPC_LD:  dec_o.op = OP_LOAD;
      OPC_AND: dec_o.op = OP_AND;
      OPC_OR:  dec_o.op = OP_OR;
      default: dec_o.op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/acc_exec_alu.sv
module acc_exec_alu
  import acc_exec_pkg::*;
(
  input  op_e              op_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] operand_i,
  output logic [ACC_W-1:0] acc_o
);

  always_comb begin
    unique case (op_i)
      OP_ADD:  acc_o = acc_i + operand_i;
      OP_SUB:  acc_o = acc_i - operand_i;
      OP_LOAD: acc_o = operand_i;
      OP_AND:  acc_o = acc_i & operand_i;
      OP_OR:   acc_o = acc_i | operand_i;
      default: acc_o = acc_i;
    endcase
  end

endmodule

// File: rtl/acc_exec.sv
module acc_exec
  import acc_exec_pkg::*;
#(
  parameter int unsigned PROG_DEPTH = DEFAULT_DEPTH,
  parameter logic [INSTR_W-1:0] PROG [PROG_DEPTH] = DEFAULT_PROG
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  output logic [ACC_W-1:0]               acc_o,
  output logic [$clog2(PROG_DEPTH+1)-1:0] pc_o,
  output logic                           halted_o
);

  localparam int unsigned PC_W = $clog2(PROG_DEPTH + 1);

  logic [PC_W-1:0]    pc_q;
  logic [ACC_W-1:0]   acc_q;
  logic               halted_q;
  logic [INSTR_W-1:0] fetch_word;
  dec_t               dec;
  logic [ACC_W-1:0]   acc_nxt;

  acc_exec_rom #(
    .DEPTH (PROG_DEPTH),
    .PC_W  (PC_W),
    .PROG  (PROG)
  ) rom_i (
    .addr_i (pc_q),
    .word_o (fetch_word)
  );

  acc_exec_decode dec_i (
    .word_i (fetch_word),
    .dec_o  (dec)
  );

  acc_exec_alu alu_i (
    .op_i      (dec.op),
    .acc_i     (acc_q),
    .operand_i (dec.operand),
    .acc_o     (acc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (dec.is_end) begin
        halted_q <= 1'b1;
      end else begin
        acc_q <= acc_nxt;
        pc_q  <= pc_q + 1'b1;
      end
    end
  end

  assign acc_o    = acc_q;
  assign pc_o     = pc_q;
  assign halted_o = halted_q;

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [15:0]      acc_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             halted_i,
  input logic [15:0]      word_i
);

  logic [7:0] opc;
  logic       known;
  assign opc   = word_i[15:8];
  assign known = opc inside {8'h09, 8'h0d, 8'h21, 8'h23, 8'h25};

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && word_i != 16'h0) |=> (!halted_i && pc_i == PC_W'($past(pc_i) + 1'b1))); // R1

  AST_ADD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && opc == 8'h09) |=>
      acc_i == 16'($past(acc_i) + {{8{$past(word_i[7])}}, $past(word_i[7:0])})); // R2

  AST_SUB_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && opc == 8'h0d) |=>
      acc_i == 16'($past(acc_i) - {{8{$past(word_i[7])}}, $past(word_i[7:0])})); // R3

  AST_LOAD_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && opc == 8'h21) |=> acc_i == {8'h00, $past(word_i[7:0])}); // R4

  AST_END_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && word_i == 16'h0) |=> (halted_i && $stable(pc_i) && $stable(acc_i))); // R7

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> (halted_i && $stable(pc_i) && $stable(acc_i))); // R7

  AST_UNKNOWN_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && word_i != 16'h0 && !known) |=> $stable(acc_i)); // R8

  AST_PC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_i <= PC_W'(DEPTH)); // R10

endmodule

bind acc_exec acc_exec_chk #(
  .DEPTH (PROG_DEPTH),
  .PC_W  (PC_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .acc_i    (acc_o),
  .pc_i     (pc_o),
  .halted_i (halted_o),
  .word_i   (fetch_word)
);

// File: tb/acc_exec_tb_top.sv
`timescale 1ns/1ps
module acc_exec_tb_top;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned PC_W  = $clog2(DEPTH + 1);
  localparam logic [15:0] TB_PROG [DEPTH] = '{
    16'h21ab, 16'h0903, 16'h09ff, 16'h0d02,
    16'h230f, 16'h25c3, 16'h0d80, 16'h2100,
    16'h09ff, 16'h0901, 16'h25f0, 16'h0055,
    16'h4e12, 16'h0000, 16'h0901, 16'h0000
  };
  localparam int unsigned RUN_DEPTH = 4;
  localparam logic [15:0] RUN_PROG [RUN_DEPTH] = '{16'h2105, 16'h0902, 16'h0d01, 16'h2503};

  typedef struct {
    logic [PC_W-1:0] pc;
    logic [15:0]     acc;
    logic            halted;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [15:0]     acc;
  logic [PC_W-1:0] pc;
  logic            halted;
  logic [15:0]     run_acc;
  logic [2:0]      run_pc;
  logic            run_halted;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  acc_exec #(.PROG_DEPTH(DEPTH), .PROG(TB_PROG)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .acc_o (acc), .pc_o (pc), .halted_o (halted)
  );

  acc_exec #(.PROG_DEPTH(RUN_DEPTH), .PROG(RUN_PROG)) dut_run_i (
    .clk_i (clk), .rst_ni (rst_ni), .acc_o (run_acc), .pc_o (run_pc), .halted_o (run_halted)
  );

  // reference stepping from the requirements
  task automatic drive_expected(input int steps);
    logic [PC_W-1:0] m_pc = '0;
    logic [15:0] m_acc = '0;
    logic m_h = 1'b0;
    exp_q.push_back('{m_pc, m_acc, m_h, "R9"});
    for (int s = 0; s < steps; s++) begin
      logic [15:0] w;
      logic [15:0] sx, zx;
      string t;
      w  = (m_pc < PC_W'(DEPTH)) ? TB_PROG[m_pc[3:0]] : 16'h0;
      sx = {{8{w[7]}}, w[7:0]};
      zx = {8'h00, w[7:0]};
      if (m_h || w == 16'h0) begin
        m_h = 1'b1;
        t = "R7";
      end else begin
        case (w[15:8])
          8'h09: begin m_acc = m_acc + sx; t = "R1 R2"; end
          8'h0d: begin m_acc = m_acc - sx; t = "R1 R3"; end
          8'h21: begin m_acc = zx;         t = "R1 R4"; end
          8'h23: begin m_acc = m_acc & zx; t = "R1 R5"; end
          8'h25: begin m_acc = m_acc | zx; t = "R1 R6"; end
          default: t = "R1 R8";
        endcase
        m_pc = m_pc + 1'b1;
      end
      exp_q.push_back('{m_pc, m_acc, m_h, t});
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, want);
    end
  endtask

  task automatic monitor();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (pc !== e.pc || acc !== e.acc || halted !== e.halted) begin
        n_fail++;
        $display("FAIL %s: pc/acc/halted got %0h/%0h/%0b expected %0h/%0h/%0b",
                 e.tag, pc, acc, halted, e.pc, e.acc, e.halted);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    drive_expected(18);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    monitor();
    // R10: program without end word halts at the depth limit
    check("R10 pc", 32'(run_pc), 32'(RUN_DEPTH));
    check("R10 acc", 32'(run_acc), 32'h7);
    check("R10 halted", 32'(run_halted), 32'h1);
    // R9: asynchronous reset clears state mid-cycle
    #3 rst_ni = 1'b0;
    #1;
    check("R9 acc", 32'(acc), 32'h0);
    check("R9 pc", 32'(pc), 32'h0);
    check("R9 halted", 32'(halted), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule